// File: doc/BRIEF.md
# Single-Instruction Move Processor Core

This block is a very small processor with exactly one instruction: copy one memory word to another. Each 16-bit instruction word carries a source address in its upper byte and a destination address in its lower byte. Arithmetic, logic and control flow are side effects of moves. The program counter, the accumulator, the flags and a set of ALU operation ports all sit in the top sixteen words of the 8-bit address space.

The core drives a single-port synchronous memory that returns read data one cycle after the address. Code starts at address 0x00 and grows upward. Data is placed below the reserved region.

Every instruction takes five cycles:
- fetch the word at the PC;
- load the source and destination holding registers;
- present the source address and increment the PC;
- capture the source word into a holding register;
- write that word to the destination.

A move whose destination is the PC address is a jump. A move whose destination is an ALU port updates the accumulator.

Top module: `move_core`

## Requirements
- R1: While `rst_n` is low, `mem_we` is 0 and `mem_addr` is 0x00. The first fetch after reset release reads address 0x00.
- R2: Every instruction takes exactly five cycles. In its first cycle `mem_addr` equals the PC. The fetched word is decoded as source = bits 15:8 and destination = bits 7:0.
- R3: In the fifth cycle of an instruction whose destination is below 0xF0, `mem_we` is 1, `mem_addr` is the destination and `mem_wdata` is the source word. A source below 0xF0 supplies the memory contents at that address.
- R4: A destination in 0xF0 to 0xFF never asserts `mem_we`.
- R5: A source in 0xF0 to 0xFF never takes external memory data. Reserved addresses other than 0xFF, 0xFE and 0xFD read as zero.
- R6: A move to 0xFF is a jump. The next fetch uses bits 7:0 of the moved word, and the step-3 increment is discarded.
- R7: Reading 0xFF yields the address of the following instruction, zero-extended to 16 bits.
- R8: A move to 0xFC adds the word to the accumulator. The carry flag takes the carry out.
- R9: A move to 0xFB subtracts the word from the accumulator (unsigned). The carry flag takes the borrow.
- R10: A move to 0xFE loads the accumulator. A move to 0xFA ANDs the word into it. Neither changes the carry flag.
- R11: A move to 0xF9 sets the accumulator to the word shifted right by one, and the carry flag takes bit 0. A move to 0xF8 sets the accumulator to the word shifted left by one, and the carry flag takes bit 15.
- R12: Reading 0xFD returns the flags: bit 0 = accumulator is zero, bit 1 = accumulator bit 15, bit 2 = carry, all other bits 0. Writes to 0xFD have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid the cycle after the address |

## Verification
The assertions take for granted that `rst_n` is deasserted away from the rising edge. They also assume the memory returns the word addressed in the previous cycle, so that the five-step schedule is the only timing source.

The stimulus keeps to this by releasing reset on a falling edge and loading each program image only while reset is held. Programs are random instruction words that may jump anywhere, including into data or the reserved region. The memory model is exact in both cases, so any fetch stays legal.

The reserved words of the memory model are filled with nonzero junk. Any leak of external data into a reserved read therefore shows up in a later memory write.

// File: rtl/move_core_pkg.sv
package move_core_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LOAD,
    ST_SRC,
    ST_READ,
    ST_WRITE
  } step_t;

  // size of the reserved top-of-memory window
  localparam int RES_WORDS = 16;

  // offsets counted down from the top address
  localparam int OFS_PC    = 0;
  localparam int OFS_ACC   = 1;
  localparam int OFS_FLAGS = 2;
  localparam int OFS_ADD   = 3;
  localparam int OFS_SUB   = 4;
  localparam int OFS_AND   = 5;
  localparam int OFS_SHR   = 6;
  localparam int OFS_SHL   = 7;

  // flag bit positions
  localparam int FLG_ZERO  = 0;
  localparam int FLG_NEG   = 1;
  localparam int FLG_CARRY = 2;

endpackage

// File: rtl/move_seq.sv
module move_seq
  import move_core_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output step_t step
);

  step_t step_d;
  step_t step_q;

  always_comb begin
    unique case (step_q)
      ST_FETCH: step_d = ST_LOAD;
      ST_LOAD:  step_d = ST_SRC;
      ST_SRC:   step_d = ST_READ;
      ST_READ:  step_d = ST_WRITE;
      default:  step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/move_alu.sv
module move_alu
  import move_core_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RES_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [RES_BITS-1:0] ofs,
  input  logic [DATA_W-1:0]   wval,
  output logic [DATA_W-1:0]   acc,
  output logic [DATA_W-1:0]   flags
);

  logic [DATA_W-1:0] acc_q, acc_d;
  logic              cy_q, cy_d;
  logic              acc_en;
  logic [DATA_W:0]   sum;
  logic [DATA_W:0]   dif;

  assign sum = {1'b0, acc_q} + {1'b0, wval};
  assign dif = {1'b0, acc_q} - {1'b0, wval};

  always_comb begin
    acc_d  = acc_q;
    cy_d   = cy_q;
    acc_en = 1'b0;
    if (wr_en) begin
      unique case (ofs)
        RES_BITS'(OFS_ACC): begin
          acc_en = 1'b1;
          acc_d  = wval;
        end
        RES_BITS'(OFS_ADD): begin
          acc_en = 1'b1;
          acc_d  = sum[DATA_W-1:0];
          cy_d   = sum[DATA_W];
        end
        RES_BITS'(OFS_SUB): begin
          acc_en = 1'b1;
          acc_d  = dif[DATA_W-1:0];
          cy_d   = dif[DATA_W];
        end
        RES_BITS'(OFS_AND): begin
          acc_en = 1'b1;
          acc_d  = acc_q & wval;
        end
        RES_BITS'(OFS_SHR): begin
          acc_en = 1'b1;
          acc_d  = wval >> 1;
          cy_d   = wval[0];
        end
        RES_BITS'(OFS_SHL): begin
          acc_en = 1'b1;
          acc_d  = wval << 1;
          cy_d   = wval[DATA_W-1];
        end
        default: acc_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  always_comb begin
    flags            = '0;
    flags[FLG_ZERO]  = (acc_q == '0);
    flags[FLG_NEG]   = acc_q[DATA_W-1];
    flags[FLG_CARRY] = cy_q;
  end

  assign acc = acc_q;

endmodule

// File: rtl/move_core.sv
module move_core
  import move_core_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int RES_BITS = $clog2(RES_WORDS);

  step_t             step_q;
  logic [ADDR_W-1:0] pc_q, pc_d, src_q, dst_q;
  logic [DATA_W-1:0] tmp_q, tmp_d, int_rd, acc, flags;
  logic              pc_en, ld_en, tmp_en;
  logic              src_res, dst_res, alu_wr;
  logic [RES_BITS-1:0] src_ofs, dst_ofs;

  // reserved window is the top RES_WORDS addresses
  assign src_res = &src_q[ADDR_W-1 -: RES_BITS];
  assign dst_res = &dst_q[ADDR_W-1 -: RES_BITS];
  assign src_ofs = ~src_q[RES_BITS-1:0];
  assign dst_ofs = ~dst_q[RES_BITS-1:0];

  move_seq i_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step_q)
  );

  assign alu_wr = (step_q == ST_WRITE) && dst_res;

  move_alu #(.DATA_W(DATA_W), .RES_BITS(RES_BITS)) i_alu (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(alu_wr),
    .ofs  (dst_ofs),
    .wval (tmp_q),
    .acc  (acc),
    .flags(flags)
  );

  always_comb begin
    unique case (src_ofs)
      RES_BITS'(OFS_PC):    int_rd = DATA_W'(pc_q);
      RES_BITS'(OFS_ACC):   int_rd = acc;
      RES_BITS'(OFS_FLAGS): int_rd = flags;
      default:              int_rd = '0;
    endcase
  end

  always_comb begin
    mem_addr = pc_q;
    mem_we   = 1'b0;
    pc_en    = 1'b0;
    pc_d     = pc_q;
    ld_en    = 1'b0;
    tmp_en   = 1'b0;
    tmp_d    = src_res ? int_rd : mem_rdata;
    unique case (step_q)
      ST_FETCH: mem_addr = pc_q;
      ST_LOAD: begin
        mem_addr = pc_q;
        ld_en    = 1'b1;
      end
      ST_SRC: begin
        mem_addr = src_q;
        pc_en    = 1'b1;
        pc_d     = pc_q + 1'b1;
      end
      ST_READ: begin
        mem_addr = src_q;
        tmp_en   = 1'b1;
      end
      default: begin
        mem_addr = dst_q;
        mem_we   = !dst_res;
        if (dst_res && (dst_ofs == RES_BITS'(OFS_PC))) begin
          pc_en = 1'b1;
          pc_d  = tmp_q[ADDR_W-1:0];
        end
      end
    endcase
  end

  assign mem_wdata = tmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (ld_en) begin
      src_q <= mem_rdata[2*ADDR_W-1:ADDR_W];
      dst_q <= mem_rdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
    end else if (tmp_en) begin
      tmp_q <= tmp_d;
    end
  end

endmodule

// File: rtl/move_core_chk.sv
module move_core_chk
  import move_core_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input step_t             step,
  input logic [ADDR_W-1:0] pc
);

  localparam int RES_BITS = $clog2(RES_WORDS);

  // R4
  we_low_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(&mem_addr[ADDR_W-1 -: RES_BITS]));

  // R3
  we_last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (step == ST_WRITE));

  // R2
  write_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_WRITE) |=> (step == ST_FETCH));

  // R2
  fetch_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FETCH) |=> (step == ST_LOAD));

  // R2
  fetch_at_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_FETCH) |-> (mem_addr == pc));

  // R7
  pc_step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_SRC) |=> (pc == $past(pc) + 1'b1));

  // R6
  pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_SRC && step != ST_WRITE) |=> $stable(pc));

endmodule

bind move_core move_core_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .step    (step_q),
  .pc      (pc_q)
);

// File: tb/test_move_core.sv
module test_move_core;

  logic        clk;
  logic        rst_n;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;

  logic [15:0] mem [256];
  logic [15:0] m   [256];
  logic        ld_en;
  logic [7:0]  ld_a;
  logic [15:0] ld_d;

  int vectors  = 0;
  int failures = 0;

  // model state
  logic [7:0]  mpc;
  logic [15:0] macc;
  logic        mcy;
  string       acc_tag;

  move_core i_move_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (ld_en)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    failures++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mflags();
    return {13'b0, mcy, macc[15], macc == 16'h0};
  endfunction

  // reference: one instruction at the architectural level
  task automatic model_step(output logic ewe, output logic [7:0] ea, output logic [15:0] ed,
                            output string tw, output string td, output logic jumped);
    logic [15:0] w, v;
    logic [7:0]  s, d, pn;
    logic [16:0] r;
    w  = m[mpc];
    s  = w[15:8];
    d  = w[7:0];
    pn = mpc + 8'd1;
    if (s >= 8'hF0) begin
      case (s)
        8'hFF:   begin v = {8'h0, pn}; td = "R7"; end
        8'hFE:   begin v = macc; td = acc_tag; end
        8'hFD:   begin v = mflags(); td = "R12"; end
        default: begin v = 16'h0; td = "R5"; end
      endcase
    end else begin
      v  = m[s];
      td = "R3";
    end
    ea = d; ed = v; ewe = (d < 8'hF0);
    jumped = 1'b0;
    tw = ewe ? "R3" : "R4";
    if (ewe) m[d] = v;
    else begin
      case (d)
        8'hFF: begin jumped = 1'b1; tw = "R6"; end
        8'hFE: begin macc = v; acc_tag = "R10"; end
        8'hFC: begin r = {1'b0, macc} + {1'b0, v}; macc = r[15:0]; mcy = r[16]; acc_tag = "R8"; end
        8'hFB: begin r = {1'b0, macc} - {1'b0, v}; macc = r[15:0]; mcy = r[16]; acc_tag = "R9"; end
        8'hFA: begin macc = macc & v; acc_tag = "R10"; end
        8'hF9: begin macc = v >> 1; mcy = v[0]; acc_tag = "R11"; end
        8'hF8: begin macc = v << 1; mcy = v[15]; acc_tag = "R11"; end
        default: ;
      endcase
    end
    mpc = jumped ? v[7:0] : pn;
  endtask

  task automatic load_and_reset();
    rst_n = 1'b0;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_a = 8'(a); ld_d = m[a];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 we in reset", {15'b0, mem_we}, 16'h0);
    check("R1 addr in reset", {8'h0, mem_addr}, 16'h0);
    mpc = 8'h00; macc = 16'h0; mcy = 1'b0; acc_tag = "R10";
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run(input int n);
    logic ewe, jmp;
    logic [7:0] ea;
    logic [15:0] ed;
    string tw, td, tf;
    tf = "R1";
    for (int i = 0; i < n; i++) begin
      check({tf, " fetch addr"}, {8'h0, mem_addr}, {8'h0, mpc});
      model_step(ewe, ea, ed, tw, td, jmp);
      repeat (4) @(negedge clk);
      #1;
      check({tw, " write enable"}, {15'b0, mem_we}, {15'b0, ewe});
      if (ewe) begin
        check({tw, " write addr"}, {8'h0, mem_addr}, {8'h0, ea});
        check({td, " write data"}, mem_wdata, ed);
      end
      tf = jmp ? "R6" : "R2";
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [15:0] ins(input logic [7:0] s, input logic [7:0] d);
    return {s, d};
  endfunction

  task automatic gen_random();
    for (int a = 0; a < 256; a++) begin
      logic [7:0] s, d;
      int p;
      p = $urandom_range(0, 9);
      s = (p < 6) ? 8'($urandom_range(8'hC0, 8'hEF)) :
          (p < 9) ? 8'($urandom_range(8'hF0, 8'hFF)) : 8'($urandom_range(0, 8'hBF));
      p = $urandom_range(0, 9);
      d = (p < 5) ? 8'($urandom_range(8'hC0, 8'hEF)) : 8'($urandom_range(8'hF0, 8'hFF));
      if (a < 8'hC0)      m[a] = ins(s, d);
      else if (a < 8'hF0) m[a] = 16'($urandom);
      else                m[a] = 16'hB000 | 16'(a) | 16'h0100; // junk, never zero
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; ld_en = 1'b0; ld_a = 8'h0; ld_d = 16'h0;
    acc_tag = "R10";

    // directed program
    for (int a = 0; a < 256; a++) m[a] = (a >= 8'hF0) ? 16'hBEEF : ins(8'hC0, 8'hE5);
    m[8'hC0] = 16'hFFFF; m[8'hC1] = 16'h0001; m[8'hC2] = 16'h8001;
    m[8'hC3] = 16'h00F0; m[8'hC4] = 16'h0014;
    m[0]  = ins(8'hC0, 8'hFE); // acc = FFFF
    m[1]  = ins(8'hC1, 8'hFC); // acc = 0, carry
    m[2]  = ins(8'hFD, 8'hE0);
    m[3]  = ins(8'hC1, 8'hFB); // acc = FFFF, borrow
    m[4]  = ins(8'hFD, 8'hE1);
    m[5]  = ins(8'hC2, 8'hF8); // acc = 0002, c = 1
    m[6]  = ins(8'hFE, 8'hE2);
    m[7]  = ins(8'hC2, 8'hF9); // acc = 4000, c = 1
    m[8]  = ins(8'hC3, 8'hFD); // ignored
    m[9]  = ins(8'hFD, 8'hE3);
    m[10] = ins(8'hFF, 8'hE4);
    m[11] = ins(8'hC4, 8'hFF); // jump to 0x14
    m[20] = ins(8'hF3, 8'hE6);
    m[21] = ins(8'hC4, 8'hFF);
    for (int a = 12; a < 20; a++) m[a] = ins(8'hC0, 8'hE5);
    m[8'hE5] = 16'h1234;
    load_and_reset();
    run(30);
    // hand-computed results
    check("R8 flags after add overflow", mem[8'hE0], 16'h0005);
    check("R9 flags after borrow", mem[8'hE1], 16'h0006);
    check("R11 shl result", mem[8'hE2], 16'h0002);
    check("R12 flags after ignored write", mem[8'hE3], 16'h0004);
    check("R7 pc read", mem[8'hE4], 16'h000B);
    check("R6 skipped code not run", mem[8'hE5], 16'h1234);
    check("R5 reserved read zero", mem[8'hE6], 16'h0000);

    // random programs
    for (int k = 0; k < 6; k++) begin
      gen_random();
      load_and_reset();
      run(300);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

endmodule